// File: doc/BRIEF.md
# Descriptor Cookie Translator

The translator turns a 20-bit descriptor cookie into the 64-bit virtual address of the descriptor that the cookie names. It does this with a two-level table walk. The upper cookie bits pick an entry in a primary page table, which sits in a small on-chip memory and holds the physical base of a secondary page. The low nine bits then pick one 8-byte slot inside that secondary page. That slot is read over a host-memory port and holds the descriptor's address.

A mode strap selects one of two primary entry layouts. In the compact layout, each 64-bit table word holds two 4-byte entries. Each entry stores a page number, and the block appends twelve zero bits to it to form the page address. In the wide layout, each 64-bit word is one full page address.

The block works on one cookie at a time. It takes a new cookie only after the previous result has been taken downstream. When the primary index falls outside the configured table, the block issues no memory reads. It returns zero with the error flag set.

Top module: `cookie_xlate`

## Requirements
- R1: `cookie_ready_o` is high only while the block is idle with no result pending, so only one translation is ever in flight.
- R2: In compact mode (`compact_mode_i`=1), the primary word address equals cookie bits 19:10.
- R3: In compact mode, cookie bit 9 = 1 selects bits 63:32 of the primary word and bit 9 = 0 selects bits 31:0. The page base is that 32-bit entry shifted left by 12, with the upper bits zero.
- R4: In wide mode (`compact_mode_i`=0), the primary word address equals cookie bits 19:9, and the whole 64-bit primary word is the page base.
- R5: The secondary read address equals the page base plus cookie bits 8:0 times 8.
- R6: The result address is the 64-bit secondary read data. With `NARROW_VA`=1, it is the low 32 bits of that data, zero-extended.
- R7: Take the primary word index (bits 19:10 in compact mode, bits 19:9 in wide mode). If it is not below `PT_BYTES`/8 (1024 by default), the block returns `result_err_o`=1 with a zero address and issues neither memory request. Otherwise `result_err_o`=0.
- R8: While `result_valid_o` is high and `result_ready_i` is low, the result valid, address and error stay unchanged.
- R9: A memory request stays valid, with a stable address, until its ready is seen. The primary request comes before the secondary one, and the two are never valid together.
- R10: After reset, `cookie_ready_o` is 1 and `result_valid_o`, `pt_req_valid_o` and `host_req_valid_o` are 0.
- R11: Each memory response is taken only on its response-valid strobe, so response latency of zero or more extra cycles, and stalled request-ready, give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cookie_valid_i | input | 1 | Cookie offered |
| cookie_ready_o | output | 1 | Cookie accepted when high with valid |
| cookie_i | input | 20 | Descriptor cookie |
| compact_mode_i | input | 1 | 1: two 4-byte primary entries per word; 0: one 8-byte entry |
| result_valid_o | output | 1 | Translation result available |
| result_ready_i | input | 1 | Downstream takes the result |
| result_addr_o | output | 64 | Translated descriptor address (zero on error) |
| result_err_o | output | 1 | Primary index out of range |
| pt_req_valid_o | output | 1 | Primary table read request |
| pt_req_ready_i | input | 1 | Primary table accepts request |
| pt_req_addr_o | output | PT_AW (10) | Primary table 64-bit word index |
| pt_rsp_valid_i | input | 1 | Primary read data valid strobe |
| pt_rsp_data_i | input | 64 | Primary read data |
| host_req_valid_o | output | 1 | Secondary slot read request |
| host_req_ready_i | input | 1 | Host memory accepts request |
| host_req_addr_o | output | 64 | Secondary slot byte address |
| host_rsp_valid_i | input | 1 | Host read data valid strobe |
| host_rsp_data_i | input | 64 | Host read data |

## Verification
The assertions assume that each memory port returns exactly one response-valid strobe per accepted request, and only after that request is accepted. They also assume no strobe arrives while nothing is outstanding. The bench memory models respect this: each model keeps a single pending slot that it fills on the request handshake and drains with one strobe after a programmable delay. The response latency and the toggling of the request-ready signals are varied per vector, so the hold properties on requests and results see stalled cycles.

// File: rtl/ct_pkg.sv
package ct_pkg;
    localparam int COOKIE_W  = 20;
    localparam int SLOT_W    = 9;   // slot offset inside a secondary page
    localparam int SLOT_LOG  = 3;   // 8-byte slots
    localparam int PT_DW     = 64;  // primary table word width
    localparam int ENTRY_W   = 32;  // compact primary entry width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PT_REQ,
        ST_PT_WAIT,
        ST_HOST_REQ,
        ST_HOST_WAIT,
        ST_DONE
    } ct_state_e;
endpackage

// File: rtl/ct_cookie_split.sv
module ct_cookie_split
    import ct_pkg::*;
#(
    parameter int PT_BYTES = 8192,
    localparam int PT_WORDS = PT_BYTES / 8,
    localparam int PT_AW    = $clog2(PT_WORDS),
    localparam int IDX_W    = COOKIE_W - SLOT_W
) (
    input  logic [COOKIE_W-1:0] cookie_i,
    input  logic                compact_i,
    output logic [PT_AW-1:0]    word_addr_o,
    output logic                half_sel_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic                range_err_o
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] word_full;

    always_comb begin
        idx         = cookie_i[COOKIE_W-1:SLOT_W];
        slot_o      = cookie_i[SLOT_W-1:0];
        half_sel_o  = idx[0];
        // compact layout: two entries per word, so the word index drops bit 0
        word_full   = compact_i ? (idx >> 1) : idx;
        range_err_o = (32'(word_full) >= PT_WORDS);
        word_addr_o = word_full[PT_AW-1:0];
    end
endmodule

// File: rtl/ct_page_base.sv
module ct_page_base
    import ct_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int ALIGN_SHIFT = 12
) (
    input  logic [PT_DW-1:0]  word_i,
    input  logic              compact_i,
    input  logic              half_sel_i,
    output logic [ADDR_W-1:0] base_o
);
    logic [ENTRY_W-1:0] entry;
    logic [ADDR_W-1:0]  compact_base;
    logic [ADDR_W-1:0]  wide_base;

    always_comb begin
        entry        = half_sel_i ? word_i[PT_DW-1:ENTRY_W] : word_i[ENTRY_W-1:0];
        compact_base = ADDR_W'(entry) << ALIGN_SHIFT;
        wide_base    = ADDR_W'(word_i);
        base_o       = compact_i ? compact_base : wide_base;
    end
endmodule

// File: rtl/ct_slot_fetch.sv
module ct_slot_fetch
    import ct_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter bit NARROW_VA = 1'b0
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [63:0]       rd_data_i,
    output logic [ADDR_W-1:0] slot_addr_o,
    output logic [63:0]       va_o
);
    always_comb begin
        slot_addr_o = base_i + (ADDR_W'(slot_i) << SLOT_LOG);
    end

    generate
        if (NARROW_VA) begin : g_narrow
            always_comb va_o = {32'd0, rd_data_i[31:0]};
        end else begin : g_wide
            always_comb va_o = rd_data_i;
        end
    endgenerate
endmodule

// File: rtl/cookie_xlate.sv
module cookie_xlate
    import ct_pkg::*;
#(
    parameter int PT_BYTES    = 8192,
    parameter int ALIGN_SHIFT = 12,
    parameter bit NARROW_VA   = 1'b0,
    localparam int ADDR_W     = 64,
    localparam int PT_AW      = $clog2(PT_BYTES / 8)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cookie_valid_i,
    output logic                cookie_ready_o,
    input  logic [COOKIE_W-1:0] cookie_i,
    input  logic                compact_mode_i,
    output logic                result_valid_o,
    input  logic                result_ready_i,
    output logic [ADDR_W-1:0]   result_addr_o,
    output logic                result_err_o,
    output logic                pt_req_valid_o,
    input  logic                pt_req_ready_i,
    output logic [PT_AW-1:0]    pt_req_addr_o,
    input  logic                pt_rsp_valid_i,
    input  logic [PT_DW-1:0]    pt_rsp_data_i,
    output logic                host_req_valid_o,
    input  logic                host_req_ready_i,
    output logic [ADDR_W-1:0]   host_req_addr_o,
    input  logic                host_rsp_valid_i,
    input  logic [63:0]         host_rsp_data_i
);
    typedef struct packed {
        ct_state_e         state;
        logic              compact;
        logic              half;
        logic [SLOT_W-1:0] slot;
        logic [PT_AW-1:0]  word;
        logic [ADDR_W-1:0] addr;   // host address, then result
        logic              err;
    } ct_regs_t;

    ct_regs_t r_d, r_q;

    logic [PT_AW-1:0]  dec_word;
    logic              dec_half;
    logic [SLOT_W-1:0] dec_slot;
    logic              dec_err;
    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] slot_addr;
    logic [63:0]       fetched_va;

    ct_cookie_split #(.PT_BYTES(PT_BYTES)) u_split (
        .cookie_i    (cookie_i),
        .compact_i   (compact_mode_i),
        .word_addr_o (dec_word),
        .half_sel_o  (dec_half),
        .slot_o      (dec_slot),
        .range_err_o (dec_err)
    );

    ct_page_base #(.ADDR_W(ADDR_W), .ALIGN_SHIFT(ALIGN_SHIFT)) u_base (
        .word_i     (pt_rsp_data_i),
        .compact_i  (r_q.compact),
        .half_sel_i (r_q.half),
        .base_o     (page_base)
    );

    ct_slot_fetch #(.ADDR_W(ADDR_W), .NARROW_VA(NARROW_VA)) u_fetch (
        .base_i      (page_base),
        .slot_i      (r_q.slot),
        .rd_data_i   (host_rsp_data_i),
        .slot_addr_o (slot_addr),
        .va_o        (fetched_va)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cookie_valid_i) begin
                    r_d.compact = compact_mode_i;
                    r_d.half    = dec_half;
                    r_d.slot    = dec_slot;
                    r_d.word    = dec_word;
                    r_d.addr    = '0;
                    r_d.err     = dec_err;
                    r_d.state   = dec_err ? ST_DONE : ST_PT_REQ;
                end
            end
            ST_PT_REQ: begin
                if (pt_req_ready_i) r_d.state = ST_PT_WAIT;
            end
            ST_PT_WAIT: begin
                if (pt_rsp_valid_i) begin
                    r_d.addr  = slot_addr;
                    r_d.state = ST_HOST_REQ;
                end
            end
            ST_HOST_REQ: begin
                if (host_req_ready_i) r_d.state = ST_HOST_WAIT;
            end
            ST_HOST_WAIT: begin
                if (host_rsp_valid_i) begin
                    r_d.addr  = fetched_va;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                if (result_ready_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cookie_ready_o   = (r_q.state == ST_IDLE);
    assign result_valid_o   = (r_q.state == ST_DONE);
    assign result_addr_o    = r_q.addr;
    assign result_err_o     = r_q.err;
    assign pt_req_valid_o   = (r_q.state == ST_PT_REQ);
    assign pt_req_addr_o    = r_q.word;
    assign host_req_valid_o = (r_q.state == ST_HOST_REQ);
    assign host_req_addr_o  = r_q.addr;
endmodule

// File: rtl/cookie_xlate_chk.sv
module cookie_xlate_chk #(
    parameter int PT_AW = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cookie_ready_o,
    input logic             result_valid_o,
    input logic             result_ready_i,
    input logic [63:0]      result_addr_o,
    input logic             result_err_o,
    input logic             pt_req_valid_o,
    input logic             pt_req_ready_i,
    input logic [PT_AW-1:0] pt_req_addr_o,
    input logic             host_req_valid_o,
    input logic             host_req_ready_i,
    input logic [63:0]      host_req_addr_o
);
    p_busy_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_valid_o || pt_req_valid_o || host_req_valid_o) |-> !cookie_ready_o);

    p_err_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_valid_o && result_err_o) |-> (result_addr_o == 64'd0));

    p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_valid_o && !result_ready_i) |=>
            (result_valid_o && $stable(result_addr_o) && $stable(result_err_o)));

    p_pt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pt_req_valid_o && !pt_req_ready_i) |=> (pt_req_valid_o && $stable(pt_req_addr_o)));

    p_host_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_req_valid_o && !host_req_ready_i) |=>
            (host_req_valid_o && $stable(host_req_addr_o)));

    p_req_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pt_req_valid_o && host_req_valid_o));

    p_pt_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pt_req_valid_o) |-> $past(cookie_ready_o));
endmodule

bind cookie_xlate cookie_xlate_chk #(.PT_AW(PT_AW)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cookie_ready_o   (cookie_ready_o),
    .result_valid_o   (result_valid_o),
    .result_ready_i   (result_ready_i),
    .result_addr_o    (result_addr_o),
    .result_err_o     (result_err_o),
    .pt_req_valid_o   (pt_req_valid_o),
    .pt_req_ready_i   (pt_req_ready_i),
    .pt_req_addr_o    (pt_req_addr_o),
    .host_req_valid_o (host_req_valid_o),
    .host_req_ready_i (host_req_ready_i),
    .host_req_addr_o  (host_req_addr_o)
);

// File: tb/cookie_xlate_bench.sv
`timescale 1ns/1ps
module cookie_xlate_bench;
    localparam int PT_AW = 10;
    localparam int NV    = 8;
    // vector: {compact, cookie[19:0], latency[2:0]}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 20'h00000, 3'd0},
        {1'b1, 20'h00200, 3'd1},
        {1'b1, 20'hFFFFF, 3'd2},
        {1'b1, 20'h5A5A5, 3'd3},
        {1'b0, 20'h7FFFF, 3'd1},
        {1'b0, 20'h12345, 3'd4},
        {1'b0, 20'h003FF, 3'd0},
        {1'b1, 20'h80001, 3'd5}
    };

    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    logic             cookie_valid = 0;
    logic             cookie_ready;
    logic [19:0]      cookie = '0;
    logic             compact = 0;
    logic             result_valid;
    logic             result_ready = 1;
    logic [63:0]      result_addr;
    logic             result_err;
    logic             pt_req_valid;
    logic             pt_req_ready = 1;
    logic [PT_AW-1:0] pt_req_addr;
    logic             pt_rsp_valid = 0;
    logic [63:0]      pt_rsp_data = '0;
    logic             host_req_valid;
    logic             host_req_ready = 1;
    logic [63:0]      host_req_addr;
    logic             host_rsp_valid = 0;
    logic [63:0]      host_rsp_data = '0;

    cookie_xlate u_cookie_xlate (
        .clk_i(clk), .rst_ni(rst_n),
        .cookie_valid_i(cookie_valid), .cookie_ready_o(cookie_ready),
        .cookie_i(cookie), .compact_mode_i(compact),
        .result_valid_o(result_valid), .result_ready_i(result_ready),
        .result_addr_o(result_addr), .result_err_o(result_err),
        .pt_req_valid_o(pt_req_valid), .pt_req_ready_i(pt_req_ready),
        .pt_req_addr_o(pt_req_addr), .pt_rsp_valid_i(pt_rsp_valid),
        .pt_rsp_data_i(pt_rsp_data),
        .host_req_valid_o(host_req_valid), .host_req_ready_i(host_req_ready),
        .host_req_addr_o(host_req_addr), .host_rsp_valid_i(host_rsp_valid),
        .host_rsp_data_i(host_rsp_data)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;
    bit stall = 0;

    function automatic logic [63:0] pt_word(input logic [PT_AW-1:0] w);
        pt_word = {32'h0040_0000 | (32'(w) * 2 + 1), 32'h0040_0000 | (32'(w) * 2)};
    endfunction

    function automatic logic [63:0] host_word(input logic [63:0] a);
        host_word = a ^ 64'hC3C3_5A5A_0F0F_A5A5;
    endfunction

    // primary table model
    int               pt_reqs = 0;
    bit               pt_pend = 0;
    int               pt_cnt = 0;
    logic [PT_AW-1:0] pt_saved = '0;
    always @(posedge clk) begin
        pt_rsp_valid <= 1'b0;
        pt_req_ready <= stall ? ~pt_req_ready : 1'b1;
        if (pt_pend) begin
            if (pt_cnt == 0) begin
                pt_rsp_valid <= 1'b1;
                pt_rsp_data  <= pt_word(pt_saved);
                pt_pend      <= 1'b0;
            end else pt_cnt <= pt_cnt - 1;
        end
        if (rst_n && pt_req_valid && pt_req_ready) begin
            pt_pend  <= 1'b1;
            pt_cnt   <= lat;
            pt_saved <= pt_req_addr;
            pt_reqs  <= pt_reqs + 1;
        end
    end

    // host memory model
    int          host_reqs = 0;
    bit          host_pend = 0;
    int          host_cnt = 0;
    logic [63:0] host_saved = '0;
    always @(posedge clk) begin
        host_rsp_valid <= 1'b0;
        host_req_ready <= stall ? ~host_req_ready : 1'b1;
        if (host_pend) begin
            if (host_cnt == 0) begin
                host_rsp_valid <= 1'b1;
                host_rsp_data  <= host_word(host_saved);
                host_pend      <= 1'b0;
            end else host_cnt <= host_cnt - 1;
        end
        if (rst_n && host_req_valid && host_req_ready) begin
            host_pend  <= 1'b1;
            host_cnt   <= lat;
            host_saved <= host_req_addr;
            host_reqs  <= host_reqs + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_of(input logic cm, input logic [19:0] ck, output logic e,
                             output logic [63:0] va, output logic [PT_AW-1:0] pa,
                             output logic [63:0] ha);
        logic [10:0] idx;
        logic [10:0] w;
        logic [63:0] wd;
        logic [63:0] base;
        idx = ck[19:9];
        w   = cm ? {1'b0, ck[19:10]} : idx;
        e   = (w >= 11'd1024);
        pa  = w[PT_AW-1:0];
        wd  = pt_word(w[PT_AW-1:0]);
        if (cm) base = {20'd0, (ck[9] ? wd[63:32] : wd[31:0]), 12'd0};
        else    base = wd;
        ha  = base + {52'd0, ck[8:0], 3'd0};
        va  = e ? 64'd0 : host_word(ha);
    endtask

    task automatic send(input logic cm, input logic [19:0] ck);
        @(negedge clk);
        cookie_valid = 1; cookie = ck; compact = cm;
        while (!cookie_ready) @(negedge clk);
        @(negedge clk);
        cookie_valid = 0;
    endtask

    task automatic get_result(output bit seen, output logic [63:0] a, output logic e);
        int n = 0;
        seen = 0; a = '0; e = 0;
        while (!result_valid && n < 200) begin @(negedge clk); n++; end
        if (result_valid) begin seen = 1; a = result_addr; e = result_err; end
    endtask

    task automatic run_one(input logic cm, input logic [19:0] ck, input string req);
        logic e_x, e_a;
        logic [63:0] va_x, ha_x, va_a;
        logic [PT_AW-1:0] pa_x;
        bit seen;
        expect_of(cm, ck, e_x, va_x, pa_x, ha_x);
        send(cm, ck);
        get_result(seen, va_a, e_a);
        check(seen, req, "result never valid", 64'd0, 64'd1);
        check(e_a == e_x, req, "error flag", 64'(e_a), 64'(e_x));
        check(va_a == va_x, req, "result address", va_a, va_x);
        if (!e_x) begin
            check(pt_saved == pa_x, req, "primary word address", 64'(pt_saved), 64'(pa_x));
            check(host_saved == ha_x, "R5", "secondary address", host_saved, ha_x);
        end
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] a0, a1;
        logic e0;
        bit seen;
        int p0, h0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(cookie_ready == 1'b1, "R10", "cookie_ready after reset", 64'(cookie_ready), 64'd1);
        check(!result_valid && !pt_req_valid && !host_req_valid, "R10", "valids after reset",
              64'({result_valid, pt_req_valid, host_req_valid}), 64'd0);
        rst_n = 1;
        @(negedge clk);

        // vector table: R2/R3 compact, R4 wide, R6 data, R11 latency
        for (int i = 0; i < NV; i++) begin
            lat = int'(VEC[i][2:0]);
            run_one(VEC[i][23], VEC[i][22:3], VEC[i][23] ? "R2_R3" : "R4");
        end

        // R11 stalled request-ready with latency
        stall = 1; lat = 2;
        run_one(1'b1, 20'h3C1F0, "R11");
        run_one(1'b0, 20'h2AAAA, "R11");
        stall = 0; lat = 0;

        // R7 out of range in wide mode: no memory reads
        p0 = pt_reqs; h0 = host_reqs;
        run_one(1'b0, 20'h80000, "R7");
        run_one(1'b0, 20'hFFFFF, "R7");
        check(pt_reqs == p0 && host_reqs == h0, "R7", "reads issued on error",
              64'(pt_reqs - p0 + host_reqs - h0), 64'd0);

        // R1/R8 result backpressure
        result_ready = 0;
        lat = 1;
        send(1'b1, 20'h00C08);
        get_result(seen, a0, e0);
        check(seen, "R8", "result never valid", 64'd0, 64'd1);
        repeat (4) @(negedge clk);
        a1 = result_addr;
        check(result_valid && a1 == a0, "R8", "held result", a1, a0);
        check(cookie_ready == 1'b0, "R1", "ready while result pending", 64'(cookie_ready), 64'd0);
        result_ready = 1;
        @(negedge clk);
        check(result_valid == 1'b0, "R8", "valid after take", 64'(result_valid), 64'd0);
        check(cookie_ready == 1'b1, "R1", "ready after take", 64'(cookie_ready), 64'd1);

        // R6 confirmed on a fresh wide cookie after backpressure
        lat = 3;
        run_one(1'b0, 20'h00001, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule